// File: doc/BRIEF.md
# Error-Rate Automatic Mute Controller

This block sits behind a digital audio decoder and watches the sample-error strobe that the decoder raises each time a parity check fails. It counts these errors in fixed windows of 128 ms, which are timed by dividing the system clock. At the close of each window it stores the count for readback. It then compares the count with two programmable thresholds and decides whether the audio output should stay on the decoded digital path or fall back to the analog FM input.

The thresholds form a hysteresis band. A window whose count is above the upper threshold raises the automatic-mute condition. A window whose count is below the lower threshold clears it. Counts inside the band, including counts equal to either threshold, leave the condition as it is.

Entering fallback always happens in two steps: the source is switched first, and the filter input is zeroed one cycle later. Leaving fallback reverses the order. A data-format indication forces the FM source unconditionally. An enable bit turns automatic muting off. The user mute request takes effect only while automatic muting is disabled.

Top module: `err_mute_ctrl`

## Requirements
- R1: An 8-bit error count increments on each cycle with `err_stb_i` high and saturates at 255. On the last cycle of each window of `WIN_CYC` clocks, the count, including any strobe in that cycle, is copied to `win_cnt_o`, and counting restarts from zero.
- R2: With `auto_dis_i` low, a window count strictly greater than `lim_hi_i` sets `am_stat_o` to 1 at the window-end clock edge.
- R3: With `auto_dis_i` low, a window count strictly less than `lim_lo_i` clears `am_stat_o` to 0 at the window-end clock edge.
- R4: A window count with `lim_lo_i <= count <= lim_hi_i` leaves `am_stat_o` unchanged.
- R5: Entering fallback: `src_fm_o` goes to 1 one cycle after `am_stat_o` rises, and `data_zero_o` goes to 1 one cycle after that. Leaving fallback: `data_zero_o` falls one cycle after `am_stat_o` falls, and `src_fm_o` falls one cycle after that.
- R6: While `am_stat_o` is 1, `mute_n_o` is 0.
- R7: While `auto_dis_i` is 1, `am_stat_o` is cleared on the next edge, and `user_mute_i` drives `mute_n_o` to 0 and `data_zero_o` to 1. While `auto_dis_i` is 0, `user_mute_i` has no effect on any output.
- R8: While `fmt_data_i` is 1, `src_fm_o` is 1, regardless of `auto_dis_i`, `fallback_en_i` or the error count.
- R9: If `fallback_en_i` is 0 when the fallback sequence would start, `src_fm_o` and `data_zero_o` stay 0, while `am_stat_o` and `mute_n_o` still report the error condition.
- R10: After reset, `win_cnt_o` is 0, `am_stat_o` is 0, `src_fm_o` and `data_zero_o` are 0, and `mute_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_stb_i | input | 1 | One pulse for each sample error |
| lim_hi_i | input | 8 | Upper threshold; a count above it raises the mute |
| lim_lo_i | input | 8 | Lower threshold; a count below it clears the mute |
| auto_dis_i | input | 1 | 1 disables automatic muting |
| fmt_data_i | input | 1 | 1 marks a data or undefined transmission format |
| fallback_en_i | input | 1 | 1 permits the switch to the FM source |
| user_mute_i | input | 1 | User mute request |
| src_fm_o | output | 1 | 1 selects the FM input; 0 selects the decoded path |
| data_zero_o | output | 1 | 1 forces the filter input data to zero |
| mute_n_o | output | 1 | Mute flag, driven low while muted |
| am_stat_o | output | 1 | Automatic-mute status bit |
| win_cnt_o | output | 8 | Error count latched at the last window end |

## Verification
The assertions assume that the thresholds, `auto_dis_i` and `fallback_en_i` are quasi-static, meaning they change only between windows. They also assume that `err_stb_i` is a clean one-cycle-per-error signal sampled on the clock. The stimulus follows these rules: it changes inputs one time unit after a rising edge, keeps the thresholds fixed, and places error bursts at known offsets inside windows. A bench-side window phase counter keeps the explicit checks aligned to window ends.

// File: rtl/err_mute_pkg.sv
package err_mute_pkg;
  localparam int unsigned CNT_W = 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/err_win_timer.sv
module err_win_timer #(
  parameter int unsigned WIN_CYC = 1048576
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic win_end_o
);
  localparam int unsigned TW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(WIN_CYC - 1);

  logic [TW-1:0] tick_q;

  assign win_end_o = (tick_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tick_q <= '0;
    else if (win_end_o) tick_q <= '0;
    else                tick_q <= tick_q + 1'b1;
  end
endmodule

// File: rtl/err_counter.sv
module err_counter
  import err_mute_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_stb_i,
  input  logic win_end_i,
  output cnt_t cnt_nxt_o,
  output cnt_t win_cnt_o
);
  cnt_t cnt_q;

  // saturating increment
  assign cnt_nxt_o = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + cnt_t'(err_stb_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      win_cnt_o <= '0;
    end else if (win_end_i) begin
      cnt_q     <= '0;
      win_cnt_o <= cnt_nxt_o;
    end else begin
      cnt_q     <= cnt_nxt_o;
    end
  end
endmodule

// File: rtl/mute_seq.sv
module mute_seq
  import err_mute_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_end_i,
  input  cnt_t cnt_i,
  input  cnt_t lim_hi_i,
  input  cnt_t lim_lo_i,
  input  logic auto_dis_i,
  input  logic fallback_en_i,
  output logic am_o,
  output logic src_o,
  output logic zero_o
);
  logic am_d;

  always_comb begin
    am_d = am_o;
    if (auto_dis_i)                      am_d = 1'b0;
    else if (win_end_i && cnt_i > lim_hi_i) am_d = 1'b1;
    else if (win_end_i && cnt_i < lim_lo_i) am_d = 1'b0;
  end

  // source moves before zeroing on entry, after it on exit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      am_o   <= 1'b0;
      src_o  <= 1'b0;
      zero_o <= 1'b0;
    end else begin
      am_o   <= am_d;
      src_o  <= am_o ? (fallback_en_i | src_o) : zero_o;
      zero_o <= am_o & src_o;
    end
  end
endmodule

// File: rtl/err_mute_ctrl.sv
module err_mute_ctrl
  import err_mute_pkg::*;
#(
  parameter int unsigned WIN_CYC = 1048576
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_stb_i,
  input  logic [CNT_W-1:0] lim_hi_i,
  input  logic [CNT_W-1:0] lim_lo_i,
  input  logic             auto_dis_i,
  input  logic             fmt_data_i,
  input  logic             fallback_en_i,
  input  logic             user_mute_i,
  output logic             src_fm_o,
  output logic             data_zero_o,
  output logic             mute_n_o,
  output logic             am_stat_o,
  output logic [CNT_W-1:0] win_cnt_o
);
  logic win_end;
  cnt_t cnt_nxt;
  logic src_q, zero_q;
  logic usr_act;

  err_win_timer #(.WIN_CYC(WIN_CYC)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_end_o(win_end)
  );

  err_counter i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_stb_i(err_stb_i),
    .win_end_i(win_end), .cnt_nxt_o(cnt_nxt), .win_cnt_o(win_cnt_o)
  );

  mute_seq i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_end_i(win_end), .cnt_i(cnt_nxt),
    .lim_hi_i(lim_hi_i), .lim_lo_i(lim_lo_i), .auto_dis_i(auto_dis_i),
    .fallback_en_i(fallback_en_i), .am_o(am_stat_o), .src_o(src_q),
    .zero_o(zero_q)
  );

  // user mute only honoured when automatic muting is off
  assign usr_act     = auto_dis_i & user_mute_i;
  assign src_fm_o    = src_q | fmt_data_i;
  assign data_zero_o = zero_q | usr_act;
  assign mute_n_o    = ~(am_stat_o | usr_act);
endmodule

// File: rtl/err_mute_chk.sv
module err_mute_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       win_end,
  input logic       src_q,
  input logic       zero_q,
  input logic       auto_dis_i,
  input logic       fmt_data_i,
  input logic       src_fm_o,
  input logic       mute_n_o,
  input logic       am_stat_o,
  input logic [7:0] win_cnt_o
);
  // R1
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end |=> $stable(win_cnt_o));
  // R4
  am_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_end && !auto_dis_i) |=> $stable(am_stat_o));
  // R5
  zero_needs_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_q |-> src_q);
  // R5
  src_after_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(src_q) |-> !zero_q && !am_stat_o);
  // R6
  mute_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    am_stat_o |-> !mute_n_o);
  // R7
  dis_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_dis_i |=> !am_stat_o);
  // R8
  fmt_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_data_i |-> src_fm_o);
endmodule

bind err_mute_ctrl err_mute_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .win_end(win_end), .src_q(src_q),
  .zero_q(zero_q), .auto_dis_i(auto_dis_i), .fmt_data_i(fmt_data_i),
  .src_fm_o(src_fm_o), .mute_n_o(mute_n_o), .am_stat_o(am_stat_o),
  .win_cnt_o(win_cnt_o)
);

// File: tb/test_err_mute_ctrl.sv
module test_err_mute_ctrl;
  localparam int CLK_PER = 10;
  localparam int N = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic err_stb = 0, auto_dis = 0, fmt_data = 0, fb_en = 1, user_mute = 0;
  logic [7:0] lim_hi = 8'd5, lim_lo = 8'd2;
  logic src_fm, data_zero, mute_n, am_stat;
  logic [7:0] win_cnt;

  int checks = 0, errors = 0, phase = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  err_mute_ctrl #(.WIN_CYC(N)) i_err_mute_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .err_stb_i(err_stb), .lim_hi_i(lim_hi),
    .lim_lo_i(lim_lo), .auto_dis_i(auto_dis), .fmt_data_i(fmt_data),
    .fallback_en_i(fb_en), .user_mute_i(user_mute), .src_fm_o(src_fm),
    .data_zero_o(data_zero), .mute_n_o(mute_n), .am_stat_o(am_stat),
    .win_cnt_o(win_cnt)
  );

  // behavioural reference
  int m_wc, m_cnt, m_win;
  bit m_am, m_src, m_zero;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wc = 0; m_cnt = 0; m_win = 0; m_am = 0; m_src = 0; m_zero = 0;
    end else begin
      bit we, o_am, o_src, o_zero;
      int cn;
      we = (m_wc == N-1);
      m_wc = we ? 0 : m_wc + 1;
      cn = m_cnt + (err_stb ? 1 : 0);
      if (cn > 255) cn = 255;
      if (we) begin m_win = cn; m_cnt = 0; end else m_cnt = cn;
      o_am = m_am; o_src = m_src; o_zero = m_zero;
      if (auto_dis) m_am = 0;
      else if (we && cn > lim_hi) m_am = 1;
      else if (we && cn < lim_lo) m_am = 0;
      m_src  = o_am ? (fb_en | o_src) : o_zero;
      m_zero = o_am & o_src;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit um;
    um = auto_dis & user_mute;
    chk("R1 win_cnt", win_cnt, m_win);
    chk("R2 am_stat", am_stat, m_am);
    chk("R5 src_fm", src_fm, m_src | fmt_data);
    chk("R5 data_zero", data_zero, m_zero | um);
    chk("R6 mute_n", mute_n, !(m_am | um));
  end

  task automatic run(int cyc, int nerr);
    for (int i = 0; i < cyc; i++) begin
      err_stb = (i < nerr);
      @(posedge clk); #1;
    end
    err_stb = 0;
    phase = (phase + cyc) % N;
  endtask

  task automatic finish_win(int nerr);
    run(N - phase, nerr);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PER*200000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10
    chk("R10 win_cnt", win_cnt, 0);
    chk("R10 am_stat", am_stat, 0);
    chk("R10 src_fm", src_fm, 0);
    chk("R10 data_zero", data_zero, 0);
    chk("R10 mute_n", mute_n, 1);
    rst_n = 1;
    run(N, 0);
    chk("R1 empty window", win_cnt, 0);
    // R2 entry and R5 ordering
    run(N, 10);
    chk("R1 count", win_cnt, 10);
    chk("R2 set", am_stat, 1);
    chk("R5 src not yet", src_fm, 0);
    run(1, 0);
    chk("R5 src first", src_fm, 1);
    chk("R5 zero later", data_zero, 0);
    chk("R6 mute low", mute_n, 0);
    run(1, 0);
    chk("R5 zero set", data_zero, 1);
    // R4 band holds
    finish_win(3);
    chk("R4 mid hold", am_stat, 1);
    run(N, 5);
    chk("R4 at upper hold", am_stat, 1);
    run(N, 2);
    chk("R4 at lower hold", am_stat, 1);
    // R3 clear and R5 release
    run(N, 1);
    chk("R3 clear", am_stat, 0);
    chk("R5 zero still", data_zero, 1);
    run(1, 0);
    chk("R5 zero released", data_zero, 0);
    chk("R5 src held", src_fm, 1);
    run(1, 0);
    chk("R5 src released", src_fm, 0);
    // R1 saturation
    finish_win(0);
    run(N, N);
    chk("R1 saturate", win_cnt, 255);
    chk("R2 set sat", am_stat, 1);
    run(N, 0);
    run(N, 0);
    chk("R3 clear again", am_stat, 0);
    // R9 no fallback
    fb_en = 0;
    run(N, 9);
    run(3, 0);
    chk("R9 am set", am_stat, 1);
    chk("R9 src kept", src_fm, 0);
    chk("R9 zero kept", data_zero, 0);
    chk("R9 mute low", mute_n, 0);
    finish_win(0);
    run(N, 0);
    fb_en = 1;
    // R8 format forces FM
    fmt_data = 1; auto_dis = 1;
    run(1, 0);
    chk("R8 forced", src_fm, 1);
    fmt_data = 0; auto_dis = 0;
    // R7 user mute ignored while enabled
    user_mute = 1;
    run(1, 0);
    chk("R7 ignored mute_n", mute_n, 1);
    chk("R7 ignored zero", data_zero, 0);
    auto_dis = 1;
    run(1, 0);
    chk("R7 user mute_n", mute_n, 0);
    chk("R7 user zero", data_zero, 1);
    user_mute = 0;
    finish_win(50);
    chk("R7 disabled no am", am_stat, 0);
    auto_dis = 0;
    run(N, 20);
    chk("R2 reenable", am_stat, 1);
    auto_dis = 1;
    run(1, 0);
    chk("R7 dis clears", am_stat, 0);
    run(4, 0);
    chk("R7 unwound", src_fm, 0);
    summary();
  end
endmodule